// File: doc/BRIEF.md
# Two-Region Access Guard

This block sits between a host access port and a storage array and decides, for every read and every write, whether the access may reach the array. It holds up to two address regions. Each region has an inclusive address window, a read-protect flag and a write-protect flag. A region can be opened by a 64-bit key, by a hardwired active-low lock pin being released, or by both together. A region with neither guard is protected permanently.

After reset the block takes its region configuration from a word-serial configuration stream that ends in a checksum word. It starts enforcing only once that stream has been checked. Before then every access is held back. A blocked read returns zero and a blocked write never reaches the array. A blocked access in the enforcing or lockout state pulses the interrupt output. If the checksum fails, the reserved configuration bits are non-zero, a wrong key is presented, or anyone tries to feed configuration again while the block is enforcing, the block enters a lockout that blocks everything. Only a reset leaves the lockout.

Top module: `prot_guard`

## Requirements
- R1: While reset is high and until enforcement starts, `active` and `lockout` are 0, `a_rd`/`a_wr` stay 0 for any host access, `h_rdata` is 0 and `irq` stays 0.
- R2: The configuration stream has NUM_REG records of seven 16-bit words and then one checksum word, each word taken on a clock edge with `cfg_vld` high. A record holds the low address, the high address, the flag word and four key words, least significant first. If the checksum equals the mod-2^16 sum of all earlier words and the flag words have bits 15:5 at zero, `active` rises on the second clock edge after the edge that takes the checksum word. Otherwise `lockout` rises on that same edge.
- R3: Flag word bits: 0 enable, 1 read-protect, 2 write-protect, 3 key guard, 4 pin guard. A region applies only when enabled and low ≤ address ≤ high. A window whose low address is above its high address matches nothing.
- R4: A read that hits a read-protected region that is not open gives `a_rd`=0 and `h_rdata`=0. An allowed read passes `a_rdata` through in the same cycle.
- R5: A write that hits a write-protected region that is not open gives `a_wr`=0 and `a_wdata`=0. An allowed write passes `h_wdata` through.
- R6: A protected region with neither guard bit set is never open.
- R7: For a key-guarded region, a key entry whose 64 bits all match opens it from the next cycle on. Any mismatch in a key entry for an enabled key-guarded region enters lockout on that edge.
- R8: For a pin-guarded region, `lock_n`=0 keeps it closed even when its key has been accepted. With `lock_n`=1, a region that is pin-guarded only is open.
- R9: `irq` is high for exactly the cycle after an edge at which an access was blocked while active or in lockout.
- R10: `cfg_vld` high while active enters lockout on that edge.
- R11: In lockout all accesses are blocked, key entries change nothing, and only reset returns the block to its reset state.
- R12: When regions overlap, an access is blocked if any matching region blocks it in that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vld | input | 1 | Configuration word valid |
| cfg_word | input | 16 | Configuration word |
| key_vld | input | 1 | Key entry strobe |
| key_sel | input | 1 | Region addressed by the key entry |
| key_val | input | 64 | Presented key |
| lock_n | input | 1 | Hardwired lock pin, low = locked |
| h_rd | input | 1 | Host read request |
| h_wr | input | 1 | Host write request |
| h_addr | input | ADDR_W | Host address |
| h_wdata | input | DATA_W | Host write data |
| h_rdata | output | DATA_W | Read data to host, zero when blocked |
| a_rd | output | 1 | Read forwarded to array |
| a_wr | output | 1 | Write forwarded to array |
| a_addr | output | ADDR_W | Address to array |
| a_wdata | output | DATA_W | Write data to array, zero when blocked |
| a_rdata | input | DATA_W | Read data from array |
| irq | output | 1 | Violation interrupt pulse |
| active | output | 1 | Protection enforced |
| lockout | output | 1 | Global lockout |

## Verification
The bench builds the block with ADDR_W=6, DATA_W=8 and NUM_REG=2. This shrinks the address space to 64 locations, so every address is swept in both directions for each configuration, key state and pin level. Windows that overlap, touch at their edges, are disabled or are empty all fit inside that space. With both regions present, the bench can check overlap priority and per-region keys, and the checksum and reserved-bit corruption cases stay cheap to reach.

// File: rtl/prot_guard_pkg.sv
package prot_guard_pkg;

    localparam int CFG_W     = 16;
    localparam int KEY_W     = 64;
    localparam int KEY_WORDS = KEY_W / CFG_W;
    localparam int KEY_POS   = 3;
    localparam int REC_WORDS = KEY_POS + KEY_WORDS;

    localparam int FLG_EN  = 0;
    localparam int FLG_RD  = 1;
    localparam int FLG_WR  = 2;
    localparam int FLG_KEY = 3;
    localparam int FLG_PIN = 4;
    localparam int FLG_NUM = 5;

    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_LOAD   = 3'd1,
        ST_CHECK  = 3'd2,
        ST_ACTIVE = 3'd3,
        ST_LOCK   = 3'd4
    } pg_state_e;

    typedef struct packed {
        logic [CFG_W-1:0] lo;
        logic [CFG_W-1:0] hi;
        logic             en;
        logic             rd;
        logic             wr;
        logic             kg;
        logic             pg;
        logic [KEY_W-1:0] key;
    } region_t;

    // A region opens only through a guard; with no guard it stays shut.
    function automatic logic region_open(input region_t r, input logic unl, input logic lock_n);
        return (r.kg | r.pg) & (~r.kg | unl) & (~r.pg | lock_n);
    endfunction

endpackage

// File: rtl/prot_guard_cfg_loader.sv
module prot_guard_cfg_loader
    import prot_guard_pkg::*;
#(
    parameter int NUM_REG = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       cfg_vld,
    input  logic [CFG_W-1:0]           cfg_word,
    output region_t [NUM_REG-1:0]      regs,
    output logic                       done,
    output logic                       cfg_ok
);
    localparam int POS_W = $clog2(REC_WORDS);
    localparam int REC_W = $clog2(NUM_REG + 1);
    localparam int SEL_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1;

    logic [POS_W-1:0]      pos;
    logic [REC_W-1:0]      rec;
    logic [SEL_W-1:0]      rsel;
    logic [CFG_W-1:0]      sum;
    logic                  sum_ok;
    logic                  rsv_bad;
    region_t [NUM_REG-1:0] regs_q;

    assign rsel = rec[SEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '0;
            rec     <= '0;
            sum     <= '0;
            done    <= 1'b0;
            sum_ok  <= 1'b0;
            rsv_bad <= 1'b0;
            regs_q  <= '0;
        end else if (en && !done && cfg_vld) begin
            if (rec == REC_W'(NUM_REG)) begin
                done   <= 1'b1;
                sum_ok <= (sum == cfg_word);
            end else begin
                sum <= sum + cfg_word;
                case (pos)
                    POS_W'(0): regs_q[rsel].lo <= cfg_word;
                    POS_W'(1): regs_q[rsel].hi <= cfg_word;
                    POS_W'(2): begin
                        regs_q[rsel].en <= cfg_word[FLG_EN];
                        regs_q[rsel].rd <= cfg_word[FLG_RD];
                        regs_q[rsel].wr <= cfg_word[FLG_WR];
                        regs_q[rsel].kg <= cfg_word[FLG_KEY];
                        regs_q[rsel].pg <= cfg_word[FLG_PIN];
                        rsv_bad <= rsv_bad | (|cfg_word[CFG_W-1:FLG_NUM]);
                    end
                    default:
                        regs_q[rsel].key[(int'(pos) - KEY_POS) * CFG_W +: CFG_W] <= cfg_word;
                endcase
                if (pos == POS_W'(REC_WORDS - 1)) begin
                    pos <= '0;
                    rec <= rec + 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    assign regs   = regs_q;
    assign cfg_ok = sum_ok & ~rsv_bad;

endmodule

// File: rtl/prot_guard_key_unit.sv
module prot_guard_key_unit
    import prot_guard_pkg::*;
#(
    parameter int NUM_REG = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  key_vld,
    input  logic                  key_sel,
    input  logic [KEY_W-1:0]      key_val,
    input  region_t [NUM_REG-1:0] regs,
    output logic [NUM_REG-1:0]    unlocked,
    output logic                  tamper
);
    logic [NUM_REG-1:0] hit;
    logic [NUM_REG-1:0] match;

    for (genvar g = 0; g < NUM_REG; g++) begin : g_key
        assign hit[g]   = en && key_vld && (key_sel == 1'(g)) && regs[g].en && regs[g].kg;
        assign match[g] = (key_val == regs[g].key);

        always_ff @(posedge clk) begin
            if (rst) begin
                unlocked[g] <= 1'b0;
            end else if (hit[g] && match[g]) begin
                unlocked[g] <= 1'b1;
            end
        end
    end

    assign tamper = |(hit & ~match);

endmodule

// File: rtl/prot_guard_region_check.sv
module prot_guard_region_check
    import prot_guard_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int NUM_REG = 2
) (
    input  region_t [NUM_REG-1:0] regs,
    input  logic [NUM_REG-1:0]    unlocked,
    input  logic                  lock_n,
    input  logic [ADDR_W-1:0]     addr,
    output logic                  rd_block,
    output logic                  wr_block
);
    logic [CFG_W-1:0]   addr_x;
    logic [NUM_REG-1:0] rb;
    logic [NUM_REG-1:0] wb;

    assign addr_x = CFG_W'(addr);

    for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
        logic hit;
        logic opened;
        assign hit    = regs[g].en && (addr_x >= regs[g].lo) && (addr_x <= regs[g].hi);
        assign opened = region_open(regs[g], unlocked[g], lock_n);
        assign rb[g]  = hit && regs[g].rd && !opened;
        assign wb[g]  = hit && regs[g].wr && !opened;
    end

    assign rd_block = |rb;
    assign wr_block = |wb;

endmodule

// File: rtl/prot_guard.sv
module prot_guard
    import prot_guard_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int DATA_W  = 16,
    parameter int NUM_REG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_vld,
    input  logic [15:0]       cfg_word,
    input  logic              key_vld,
    input  logic              key_sel,
    input  logic [63:0]       key_val,
    input  logic              lock_n,
    input  logic              h_rd,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [DATA_W-1:0] h_wdata,
    output logic [DATA_W-1:0] h_rdata,
    output logic              a_rd,
    output logic              a_wr,
    output logic [ADDR_W-1:0] a_addr,
    output logic [DATA_W-1:0] a_wdata,
    input  logic [DATA_W-1:0] a_rdata,
    output logic              irq,
    output logic              active,
    output logic              lockout
);
    pg_state_e             state;
    pg_state_e             state_nxt;
    region_t [NUM_REG-1:0] regs;
    logic                  cfg_done;
    logic                  cfg_ok;
    logic [NUM_REG-1:0]    unlocked;
    logic                  key_tamper;
    logic                  rd_block;
    logic                  wr_block;
    logic                  rd_ok;
    logic                  wr_ok;
    logic                  enforcing;

    prot_guard_cfg_loader #(.NUM_REG(NUM_REG)) u_loader (
        .clk      (clk),
        .rst      (rst),
        .en       (state == ST_LOAD),
        .cfg_vld  (cfg_vld),
        .cfg_word (cfg_word),
        .regs     (regs),
        .done     (cfg_done),
        .cfg_ok   (cfg_ok)
    );

    prot_guard_key_unit #(.NUM_REG(NUM_REG)) u_key (
        .clk      (clk),
        .rst      (rst),
        .en       (state == ST_ACTIVE),
        .key_vld  (key_vld),
        .key_sel  (key_sel),
        .key_val  (key_val),
        .regs     (regs),
        .unlocked (unlocked),
        .tamper   (key_tamper)
    );

    prot_guard_region_check #(.ADDR_W(ADDR_W), .NUM_REG(NUM_REG)) u_check (
        .regs     (regs),
        .unlocked (unlocked),
        .lock_n   (lock_n),
        .addr     (h_addr),
        .rd_block (rd_block),
        .wr_block (wr_block)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RESET:  state_nxt = ST_LOAD;
            ST_LOAD:   if (cfg_done) state_nxt = ST_CHECK;
            ST_CHECK:  state_nxt = cfg_ok ? ST_ACTIVE : ST_LOCK;
            ST_ACTIVE: if (cfg_vld || key_tamper) state_nxt = ST_LOCK;
            ST_LOCK:   state_nxt = ST_LOCK;
            default:   state_nxt = ST_LOCK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RESET;
        end else begin
            state <= state_nxt;
        end
    end

    assign enforcing = (state == ST_ACTIVE) || (state == ST_LOCK);
    assign rd_ok     = (state == ST_ACTIVE) && !rd_block;
    assign wr_ok     = (state == ST_ACTIVE) && !wr_block;

    assign a_rd    = h_rd && rd_ok;
    assign a_wr    = h_wr && wr_ok;
    assign a_addr  = h_addr;
    assign a_wdata = wr_ok ? h_wdata : '0;
    assign h_rdata = (h_rd && rd_ok) ? a_rdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else begin
            irq <= enforcing && ((h_rd && !rd_ok) || (h_wr && !wr_ok));
        end
    end

    assign active  = (state == ST_ACTIVE);
    assign lockout = (state == ST_LOCK);

endmodule

// File: rtl/prot_guard_chk.sv
module prot_guard_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_vld,
    input logic              h_rd,
    input logic              h_wr,
    input logic [DATA_W-1:0] h_rdata,
    input logic              a_rd,
    input logic              a_wr,
    input logic [DATA_W-1:0] a_wdata,
    input logic              irq,
    input logic              active,
    input logic              lockout
);
    AST_NO_ARRAY_OFF: assert property (@(posedge clk) disable iff (rst) !active |-> (!a_rd && !a_wr)); // R1
    AST_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst) (h_rd && !a_rd) |-> (h_rdata == '0)); // R4
    AST_WDATA_DROPPED: assert property (@(posedge clk) disable iff (rst) (h_wr && !a_wr) |-> (a_wdata == '0)); // R5
    AST_IRQ_ON_BLOCK: assert property (@(posedge clk) disable iff (rst) ((active || lockout) && ((h_rd && !a_rd) || (h_wr && !a_wr))) |=> irq); // R9
    AST_CFG_TAMPER: assert property (@(posedge clk) disable iff (rst) (active && cfg_vld) |=> lockout); // R10
    AST_LOCKOUT_STICKY: assert property (@(posedge clk) disable iff (rst) lockout |=> lockout); // R11
endmodule

bind prot_guard prot_guard_chk #(.DATA_W(DATA_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_vld (cfg_vld),
    .h_rd    (h_rd),
    .h_wr    (h_wr),
    .h_rdata (h_rdata),
    .a_rd    (a_rd),
    .a_wr    (a_wr),
    .a_wdata (a_wdata),
    .irq     (irq),
    .active  (active),
    .lockout (lockout)
);

// File: tb/test_prot_guard.sv
module test_prot_guard;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int NR = 2;
    localparam logic [63:0] K0 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] K1 = 64'hFEDC_BA98_7654_3210;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_vld = 1'b0;
    logic [15:0]   cfg_word = '0;
    logic          key_vld = 1'b0;
    logic          key_sel = 1'b0;
    logic [63:0]   key_val = '0;
    logic          lock_n = 1'b0;
    logic          h_rd = 1'b0;
    logic          h_wr = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [DW-1:0] h_wdata = '0;
    logic [DW-1:0] h_rdata;
    logic          a_rd;
    logic          a_wr;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_wdata;
    logic [DW-1:0] a_rdata;
    logic          irq;
    logic          active;
    logic          lockout;

    int checks = 0;
    int fails  = 0;

    // bench model: 0 loading, 1 enforcing, 2 lockout
    int          mode = 0;
    int          lo_m [NR];
    int          hi_m [NR];
    logic [15:0] fl_m [NR];
    logic [63:0] key_m [NR];
    bit          unl [NR];

    always #4 clk = ~clk;

    assign a_rdata = {2'b10, a_addr};

    prot_guard #(.ADDR_W(AW), .DATA_W(DW), .NUM_REG(NR)) i_prot_guard (
        .clk(clk), .rst(rst), .cfg_vld(cfg_vld), .cfg_word(cfg_word),
        .key_vld(key_vld), .key_sel(key_sel), .key_val(key_val), .lock_n(lock_n),
        .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .a_rd(a_rd), .a_wr(a_wr), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .irq(irq), .active(active), .lockout(lockout)
    );

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit allow(int a, bit wr);
        if (mode != 1) return 1'b0;
        for (int r = 0; r < NR; r++) begin
            if (fl_m[r][0] && a >= lo_m[r] && a <= hi_m[r]) begin
                bit prot;
                bit opened;
                prot   = wr ? fl_m[r][2] : fl_m[r][1];
                opened = (fl_m[r][3] | fl_m[r][4]) && (!fl_m[r][3] || unl[r]) && (!fl_m[r][4] || lock_n);
                if (prot && !opened) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    task automatic op(string scen, int a, bit wr);
        bit e;
        logic [DW-1:0] wd;
        @(negedge clk);
        wd = DW'(a * 7 + 3);
        h_addr = AW'(a); h_rd = !wr; h_wr = wr; h_wdata = wd;
        #1;
        e = allow(a, wr);
        if (wr) begin
            chk("R5", {scen, " a_wr"}, a_wr, e);
            chk("R5", {scen, " a_wdata"}, a_wdata, e ? wd : '0);
        end else begin
            chk("R4", {scen, " a_rd"}, a_rd, e);
            chk("R4", {scen, " h_rdata"}, h_rdata, e ? {2'b10, AW'(a)} : '0);
        end
        @(posedge clk); #1;
        chk("R9", {scen, " irq"}, irq, (!e && mode != 0));
    endtask

    task automatic idle();
        @(negedge clk);
        h_rd = 1'b0; h_wr = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic sweep(string scen);
        for (int a = 0; a < (1 << AW); a++) begin
            op(scen, a, 1'b0);
            op(scen, a, 1'b1);
        end
        idle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        mode = 0;
        for (int r = 0; r < NR; r++) unl[r] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset active", active, 0);
        chk("R1", "reset lockout", lockout, 0);
        chk("R1", "reset irq", irq, 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic load(int lo0, int hi0, logic [15:0] f0, logic [63:0] k0,
                        int lo1, int hi1, logic [15:0] f1, logic [63:0] k1, int bump);
        logic [15:0] w [15];
        logic [15:0] sum;
        bit bad;
        lo_m[0] = lo0; hi_m[0] = hi0; fl_m[0] = f0; key_m[0] = k0;
        lo_m[1] = lo1; hi_m[1] = hi1; fl_m[1] = f1; key_m[1] = k1;
        for (int r = 0; r < NR; r++) begin
            w[r*7 + 0] = 16'(lo_m[r]);
            w[r*7 + 1] = 16'(hi_m[r]);
            w[r*7 + 2] = fl_m[r];
            for (int k = 0; k < 4; k++) w[r*7 + 3 + k] = key_m[r][k*16 +: 16];
        end
        sum = '0;
        for (int i = 0; i < 14; i++) sum = sum + w[i];
        w[14] = sum + 16'(bump);
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            cfg_vld = 1'b1; cfg_word = w[i];
        end
        @(negedge clk);
        cfg_vld = 1'b0;
        chk("R2", "active one edge after checksum", active, 0);
        chk("R2", "lockout one edge after checksum", lockout, 0);
        @(negedge clk);
        chk("R2", "active two edges after checksum", active, 0);
        bad = (bump != 0) || (|f0[15:5]) || (|f1[15:5]);
        @(negedge clk);
        mode = bad ? 2 : 1;
        chk("R2", "active after check", active, !bad);
        chk("R2", "lockout after check", lockout, bad);
    endtask

    task automatic give_key(int r, logic [63:0] k);
        @(negedge clk);
        key_vld = 1'b1; key_sel = r[0]; key_val = k;
        @(posedge clk);
        if (mode == 1 && fl_m[r][0] && fl_m[r][3]) begin
            if (k == key_m[r]) unl[r] = 1'b1;
            else mode = 2;
        end
        @(negedge clk);
        key_vld = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        op("R1 before load", 5, 1'b0);
        op("R1 before load", 5, 1'b1);
        idle();

        // R8 R12: region 0 read-protected, unguarded; region 1 write-protected, pin-guarded, overlap 16..20
        load(8, 20, 16'h0003, K0, 16, 40, 16'h0015, K1, 0);
        lock_n = 1'b0;
        sweep("R8 R12 pin low");
        lock_n = 1'b1;
        sweep("R6 R8 pin high");

        // R7: key-guarded regions, region 1 also pin-guarded
        do_reset();
        lock_n = 1'b0;
        load(0, 15, 16'h000F, K0, 10, 30, 16'h001B, K1, 0);
        sweep("R7 no keys");
        give_key(0, K0);
        sweep("R7 key region0");
        give_key(1, K1);
        sweep("R8 key given pin low");
        lock_n = 1'b1;
        sweep("R7 R8 both open");
        give_key(1, K1 ^ 64'h1);
        chk("R7", "lockout after wrong key", lockout, 1);
        chk("R7", "active after wrong key", active, 0);
        sweep("R11 lockout");
        give_key(0, K0);
        @(negedge clk);
        chk("R11", "key in lockout ignored", lockout, 1);
        op("R11 after key", 3, 1'b0);
        idle();
        do_reset();
        chk("R11", "reset leaves lockout", lockout, 0);

        // R3: disabled region and empty window
        load(0, 63, 16'h0006, K0, 50, 20, 16'h0007, K1, 0);
        sweep("R3 disabled and empty");

        // R2: checksum mismatch
        do_reset();
        load(8, 20, 16'h0003, K0, 16, 40, 16'h0015, K1, 1);
        op("R2 bad checksum", 30, 1'b0);
        op("R2 bad checksum", 30, 1'b1);
        idle();

        // R2: reserved flag bit set with a matching checksum
        do_reset();
        load(8, 20, 16'h0003, K0, 16, 40, 16'h0095, K1, 0);
        op("R2 reserved bit", 60, 1'b1);
        idle();

        // R10: configuration word while enforcing
        do_reset();
        lock_n = 1'b1;
        load(8, 20, 16'h0003, K0, 16, 40, 16'h0015, K1, 0);
        op("R10 before tamper", 30, 1'b1);
        idle();
        @(negedge clk);
        cfg_vld = 1'b1; cfg_word = 16'h1234;
        @(posedge clk);
        mode = 2;
        @(negedge clk);
        cfg_vld = 1'b0;
        chk("R10", "lockout after cfg word", lockout, 1);
        op("R10 after tamper", 30, 1'b1);
        op("R10 after tamper", 2, 1'b0);
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule